// File: doc/BRIEF.md
# Cascadable Four-Bit Arithmetic Logic Slice

This block is a purely combinational arithmetic and logic unit built from four-bit slices. Each slice takes two four-bit operands, a three-bit operation code and a carry input. It returns a four-bit result, a carry output and a two's-complement overflow flag. Eight operation codes are available: three arithmetic operations (sum, and subtraction in either direction), three bitwise operations, and two codes that force the result to a constant.

The top module chains `SLICES` slices in ripple fashion. The carry output of each slice drives the carry input of the next more significant slice, so the default of four slices acts as one 16-bit ALU. Subtraction adds one operand to the ones' complement of the other plus the carry input. A correct difference therefore needs the carry input held at 1. The overflow flag of the whole unit comes from the most significant slice only.

Top module: `alu_ripple_top`

## Requirements
- R1: The operation code `op_sel` (bit 0 least significant) selects: 0 clear, 1 B minus A, 2 A minus B, 3 A plus B, 4 A XOR B, 5 A OR B, 6 A AND B, 7 preset.
- R2: With code 0 the result is all zeros for any operands and carry input.
- R3: With code 7 the result is all ones for any operands and carry input.
- R4: With code 3, `{cout, result}` equals A + B + `cin`; for example, with four-bit operands, 1111 + 1111 + 1 gives result 1111 and cout 1.
- R5: With code 2, `{cout, result}` equals A + (ones' complement of B) + `cin`; with `cin`=1 the result is the true difference A minus B, and cout is 1 when no borrow occurs.
- R6: With code 1, `{cout, result}` equals B + (ones' complement of A) + `cin`; with `cin`=0 and A=B=0 the result is all ones and cout is 0.
- R7: In the arithmetic codes, `ovf` is the XOR of the carry into the top result bit and the carry out of it (for example 0111 + 0001 + 0 sets `ovf`).
- R8: Codes 4, 5 and 6 give the bitwise XOR, OR and AND of A and B, and `cin` has no effect on the result.
- R9: In codes 0, 4, 5, 6 and 7, both `cout` and `ovf` are 0.
- R10: Slices chain in ripple order, so that the unit behaves as one ALU of 4×`SLICES` bits. The final carry and the overflow flag come from the most significant slice.
- R11: The outputs follow input changes without any clock. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code |
| cin | input | 1 | Carry into the least significant slice |
| opnd_a | input | 4×SLICES | Operand A |
| opnd_b | input | 4×SLICES | Operand B |
| result | output | 4×SLICES | Function result |
| cout | output | 1 | Carry out of the most significant slice |
| ovf | output | 1 | Two's-complement overflow of the whole word |

## Verification
The single-slice configuration is driven through every combination of operands, code and carry input (4096 cases). This separates an error in one code's decode from an error in one bit's carry logic. The 16-bit configuration gets random operands under every code, which exposes faults in the carry hand-off between slices and in the source of the top-level overflow flag. Directed cases cover the constant codes, subtraction with the carry input left at 0, the all-ones sum, and a signed overflow at the word boundary.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    localparam int SLICE_W = 4;

    typedef enum logic [2:0] {
        OP_CLEAR  = 3'd0,
        OP_B_SUB  = 3'd1,
        OP_A_SUB  = 3'd2,
        OP_ADD    = 3'd3,
        OP_XOR    = 3'd4,
        OP_OR     = 3'd5,
        OP_AND    = 3'd6,
        OP_PRESET = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic [SLICE_W-1:0] f;
        logic               carry;
        logic               ovf;
    } slice_res_t;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
    import alu_slice_pkg::*;
#(
    parameter int N = SLICE_W
) (
    input  alu_op_e        op,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [N-1:0]   x,
    output logic [N-1:0]   y,
    output logic           arith
);

    // R1: arithmetic codes pick the adder operands, the rest park them.
    always_comb begin
        x     = '0;
        y     = '0;
        arith = 1'b0;
        unique case (op)
            OP_B_SUB: begin x = b; y = ~a; arith = 1'b1; end
            OP_A_SUB: begin x = a; y = ~b; arith = 1'b1; end
            OP_ADD:   begin x = a; y = b;  arith = 1'b1; end
            default:  begin x = '0; y = '0; arith = 1'b0; end
        endcase
    end

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int N = 4
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         c_top_in,
    output logic         c_out
);

    logic [N:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < N; i++) begin : g_fa
        assign sum[i]  = x[i] ^ y[i] ^ c[i];
        assign c[i+1]  = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
    end

    assign c_top_in = c[N-1];
    assign c_out    = c[N];

endmodule

// File: rtl/alu_bitwise_unit.sv
module alu_bitwise_unit
    import alu_slice_pkg::*;
#(
    parameter int N = SLICE_W
) (
    input  alu_op_e      op,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] f
);

    // R2 R3 R8: constants and bitwise functions.
    always_comb begin
        unique case (op)
            OP_XOR:    f = a ^ b;
            OP_OR:     f = a | b;
            OP_AND:    f = a & b;
            OP_PRESET: f = '1;
            default:   f = '0;
        endcase
    end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_slice_pkg::*;
(
    input  alu_op_e              op,
    input  logic                 cin,
    input  logic [SLICE_W-1:0]   a,
    input  logic [SLICE_W-1:0]   b,
    output slice_res_t           res
);

    logic [SLICE_W-1:0] x, y, sum, lf;
    logic               arith, c_top_in, c_out;
    slice_res_t         res_d;

    alu_operand_prep #(.N(SLICE_W)) prep_i (
        .op(op), .a(a), .b(b), .x(x), .y(y), .arith(arith)
    );

    alu_ripple_adder #(.N(SLICE_W)) add_i (
        .x(x), .y(y), .cin(cin), .sum(sum),
        .c_top_in(c_top_in), .c_out(c_out)
    );

    alu_bitwise_unit #(.N(SLICE_W)) bit_i (
        .op(op), .a(a), .b(b), .f(lf)
    );

    // R7 R9: flags only in arithmetic codes.
    always_comb begin
        res_d = '0;
        if (arith) begin
            res_d.f     = sum;
            res_d.carry = c_out;
            res_d.ovf   = c_top_in ^ c_out;
        end else begin
            res_d.f     = lf;
            res_d.carry = 1'b0;
            res_d.ovf   = 1'b0;
        end
    end

    assign res = res_d;

endmodule

// File: rtl/alu_ripple_top.sv
module alu_ripple_top
    import alu_slice_pkg::*;
#(
    parameter int SLICES = 4,
    localparam int W     = SLICES * SLICE_W
) (
    input  logic [2:0]   op_sel,
    input  logic         cin,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         cout,
    output logic         ovf
);

    alu_op_e            op;
    logic [SLICES:0]    chain_d;
    logic [SLICES-1:0]  ovf_d;

    assign op         = alu_op_e'(op_sel);
    assign chain_d[0] = cin;

    // R10: ripple chain, slice i feeds slice i+1.
    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        slice_res_t sres;
        alu_slice slice_i (
            .op(op),
            .cin(chain_d[i]),
            .a(opnd_a[i*SLICE_W +: SLICE_W]),
            .b(opnd_b[i*SLICE_W +: SLICE_W]),
            .res(sres)
        );
        assign result[i*SLICE_W +: SLICE_W] = sres.f;
        assign chain_d[i+1]                 = sres.carry;
        assign ovf_d[i]                     = sres.ovf;
    end

    assign cout = chain_d[SLICES];
    assign ovf  = ovf_d[SLICES-1];

endmodule

// File: rtl/alu_ripple_chk.sv
module alu_ripple_chk #(
    parameter int W = 16
) (
    input logic [2:0]   op_sel,
    input logic         cin,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic         cout,
    input logic         ovf
);

    always_comb begin
        if (!$isunknown({op_sel, cin, opnd_a, opnd_b})) begin
            // R2
            clear_zero_chk: assert (op_sel != 3'd0 || result == '0);
            // R3
            preset_ones_chk: assert (op_sel != 3'd7 || result == '1);
            // R9
            logic_flags_chk: assert (op_sel == 3'd1 || op_sel == 3'd2 || op_sel == 3'd3
                                     || (!cout && !ovf));
            // R4
            add_sum_chk: assert (op_sel != 3'd3 ||
                {cout, result} == ({1'b0, opnd_a} + {1'b0, opnd_b} + (W+1)'(cin)));
            // R5
            a_sub_chk: assert (op_sel != 3'd2 ||
                {cout, result} == ({1'b0, opnd_a} + {1'b0, ~opnd_b} + (W+1)'(cin)));
            // R7
            add_ovf_chk: assert (op_sel != 3'd3 ||
                ovf == ((opnd_a[W-1] == opnd_b[W-1]) && (result[W-1] != opnd_a[W-1])));
        end
    end

endmodule

bind alu_ripple_top alu_ripple_chk #(.W(W)) chk_i (
    .op_sel(op_sel), .cin(cin), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .cout(cout), .ovf(ovf)
);

// File: tb/alu_ripple_top_tb_top.sv
module alu_ripple_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [2:0]    op_sel;
    logic          cin;
    logic [WB-1:0] a16, b16, r16;
    logic          co16, ov16;
    logic [3:0]    a4, b4, r4;
    logic          co4, ov4;

    alu_ripple_top dut_i (
        .op_sel(op_sel), .cin(cin), .opnd_a(a16), .opnd_b(b16),
        .result(r16), .cout(co16), .ovf(ov16)
    );

    alu_ripple_top #(.SLICES(1)) slice_i (
        .op_sel(op_sel), .cin(cin), .opnd_a(a4), .opnd_b(b4),
        .result(r4), .cout(co4), .ovf(ov4)
    );

    // Behavioural reference, R1 code map: returns {ovf, cout, f}.
    function automatic longint ref_alu(int w, int op, longint a, longint b, int ci);
        longint mask = (longint'(1) << w) - 1;
        longint hm   = mask >> 1;
        longint x = 0, y = 0, s, f;
        int co, ov, cm;
        case (op)
            0: return 0;
            7: return mask;
            4: return (a ^ b) & mask;
            5: return (a | b) & mask;
            6: return (a & b) & mask;
            1: begin x = b; y = (~a) & mask; end
            2: begin x = a; y = (~b) & mask; end
            default: begin x = a; y = b; end
        endcase
        s  = x + y + ci;
        f  = s & mask;
        co = int'((s >> w) & 1);
        cm = int'((((x & hm) + (y & hm) + ci) >> (w - 1)) & 1);
        ov = cm ^ co;
        return (longint'(ov) << (w + 1)) | (longint'(co) << w) | f;
    endfunction

    function automatic string op_tag(int op);
        case (op)
            0: return "R2";
            7: return "R3";
            3: return "R4";
            2: return "R5";
            1: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, longint act, longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d cin=%0d: actual %h expected %h", tag, op_sel, cin, act, exp);
        end
    endtask

    // Drive after a rising edge, compare at the falling edge (R11: no clock involved).
    task automatic apply(int op, int ci, longint a, longint b, bit wide, string tag);
        longint e, act;
        int w = wide ? WB : 4;
        @(posedge clk);
        op_sel = 3'(op); cin = ci[0];
        if (wide) begin a16 = WB'(a); b16 = WB'(b); end
        else begin a4 = 4'(a); b4 = 4'(b); end
        @(negedge clk);
        e = ref_alu(w, op, a, b, ci);
        if (wide) act = (longint'(ov16) << 17) | (longint'(co16) << 16) | longint'(r16);
        else      act = (longint'(ov4) << 5) | (longint'(co4) << 4) | longint'(r4);
        check(tag, act & ((longint'(1) << w) - 1), e & ((longint'(1) << w) - 1));
        check((op >= 4 || op == 0) ? "R9" : "R7", act >> w, e >> w);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        op_sel = 3'd0; cin = 1'b0; a16 = '0; b16 = '0; a4 = '0; b4 = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: quiescent state with zero inputs
        check("R2", {ov16, co16, r16}, 18'h0);

        // Directed corners
        apply(1, 0, 0, 0, 0, "R6");          // B-A, cin 0: 1111, cout 0
        apply(3, 1, 15, 15, 0, "R4");        // 1111+1111+1: 1111, cout 1
        apply(3, 0, 7, 1, 0, "R7");          // signed overflow in slice
        apply(2, 1, 16'h8000, 1, 1, "R7");   // 16-bit overflow at top slice
        apply(0, 1, 16'hFFFF, 16'hFFFF, 1, "R2");
        apply(7, 0, 0, 0, 1, "R3");
        apply(2, 1, 16'h1234, 16'h0235, 1, "R5");
        apply(4, 1, 16'hA5A5, 16'h0FF0, 1, "R8");  // cin ignored

        // R1 R11: exhaustive single slice
        for (int op = 0; op < 8; op++)
            for (int ci = 0; ci < 2; ci++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++)
                        apply(op, ci, a, b, 0, op_tag(op));

        // R10: random 16-bit cascade
        for (int k = 0; k < 2000; k++)
            apply(k % 8, int'($urandom_range(0, 1)), longint'($urandom_range(0, 65535)),
                  longint'($urandom_range(0, 65535)), 1, "R10");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule